// File: doc/BRIEF.md
# Two-Wire Register Slave with Commit-on-Stop

This block is a synthesizable slave for a two-wire serial bus (I2C-style, 7-bit addressing). A host controller uses it to reach a small bank of byte registers. A two-bit strap input picks one of four device addresses. Every write first carries a 16-bit register address, sent high byte first, and then one or more data bytes. The data bytes go to consecutive registers, and the register index wraps within the bank.

Write data does not reach the registers straight away. It collects in a staging buffer and is copied into the live registers in a single clock cycle, and only when a stop condition closes the transfer. A repeated START, or a NACK from the slave, throws the staged bytes away. Reads use the combined format: a write phase sets the pointer, then a repeated START with the read bit returns bytes from that pointer, stepping forward after each byte, until the host NACKs.

Register index 0 holds a read-only identity byte. It reports the role, the interrupt polarity and the address strap. The block also drives an interrupt output whose active edge is set by a polarity input.

Top module: `tws_slave`

## Requirements
- R1: The slave ACKs its own address, which is 0x62, 0x72, 0x60 or 0x70 for `addr_sel` 00, 01, 10 and 11. It ignores any other address: SDA stays released and no ACK is given.
- R2: In a write, the two bytes after the device address form the register pointer, high byte first. Each data byte then goes to the register at index pointer mod 16, and the pointer steps by one after each byte.
- R3: The live registers stay unchanged until a stop condition ends the write. All staged bytes then appear together.
- R4: A repeated START that arrives before the stop discards the staged bytes, and no register changes.
- R5: The staging buffer holds 16 data bytes. A 17th data byte is NACKed, and the whole write is discarded.
- R6: A combined read returns the byte at the pointer, then the following registers, until the host NACKs.
- R7: Index 0 is read-only and returns an identity byte. Bit 7 is 1, bits 6:5 are 0, bits 4:3 are `addr_sel`, bit 2 is `irq_pol`, bit 1 is the role (1 = receiver) and bit 0 is 0. Writes to index 0 have no effect.
- R8: `irq_o` follows `irq_src` one clock later when `irq_pol`=1, and follows its inverse when `irq_pol`=0. An event therefore gives a rising edge or a falling edge, as the polarity selects.
- R9: During reset, SDA is released, `irq_o` is 0 and registers 1 to 15 read 0.
- R10: SDA is open-drain: `sda_oe`=1 pulls the line low. `sda_oe` changes only while the synchronised SCL is low, and it is 0 after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_sel | input | 2 | Device address strap |
| irq_pol | input | 1 | Interrupt polarity: 1 rising, 0 falling |
| irq_src | input | 1 | Interrupt event from the core |
| irq_o | output | 1 | Interrupt line to the host |
| regs_o | output | 128 | Live registers, byte i at bits 8i+7:8i (byte 0 is the identity byte) |

## Verification
The checker watches four rules on every cycle. The live registers change only in the cycle after a detected stop. The staging count never exceeds its capacity. SDA drive changes only while SCL is low and is released after a stop. The interrupt level follows the event and the polarity.

Address matching, the high-byte-first pointer, index wrap, discard on repeated START or overflow, the identity byte and multi-byte reads depend on whole bus transfers. Only the bench scenarios, which act as a bus master, can show these.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} tws_st_e;
  typedef enum logic [1:0] {P_DEV, P_AHI, P_ALO, P_DATA} tws_ph_e;

  function automatic logic [6:0] tws_dev_addr(input logic [1:0] sel);
    case (sel)
      2'b00:   return 7'h62;
      2'b01:   return 7'h72;
      2'b10:   return 7'h60;
      default: return 7'h70;
    endcase
  endfunction
endpackage

// File: rtl/tws_busmon.sv
module tws_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tws_regbank.sv
module tws_regbank #(
  parameter  int NREG  = 16,
  parameter  int DEPTH = 16,
  localparam int RIW   = $clog2(NREG),
  localparam int SIW   = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_clr,
  input  logic              stg_push,
  input  logic [7:0]        stg_din,
  input  logic              base_ld,
  input  logic [RIW-1:0]    base_in,
  input  logic              commit,
  input  logic [RIW-1:0]    rd_idx,
  input  logic [7:0]        id_byte,
  output logic [7:0]        rd_byte,
  output logic [CW-1:0]     stg_cnt,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0]     live_q  [NREG];
  logic [7:0]     live_n  [NREG];
  logic [7:0]     stage_q [DEPTH];
  logic [7:0]     stage_n [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [RIW-1:0] base_q, base_n;

  always_comb begin
    logic [RIW-1:0] off;
    off     = '0;
    live_n  = live_q;
    stage_n = stage_q;
    cnt_n   = cnt_q;
    base_n  = base_ld ? base_in : base_q;
    if (stg_clr) begin
      cnt_n = '0;
    end else if (stg_push) begin
      stage_n[cnt_q[SIW-1:0]] = stg_din;
      cnt_n = cnt_q + 1'b1;
    end else if (commit) begin
      for (int i = 1; i < NREG; i++) begin
        off = RIW'(i) - base_q;
        if (int'(off) < int'(cnt_q)) live_n[i] = stage_q[off[SIW-1:0]];
      end
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)  live_q[i]  <= '0;
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      live_q  <= live_n;
      stage_q <= stage_n;
      cnt_q   <= cnt_n;
      base_q  <= base_n;
    end
  end

  assign rd_byte = (rd_idx == '0) ? id_byte : live_q[rd_idx];
  assign stg_cnt = cnt_q;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    if (g == 0) begin : g_id
      assign regs_o[7:0] = id_byte;
    end else begin : g_live
      assign regs_o[g*8 +: 8] = live_q[g];
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter  int NREG    = 16,
  parameter  int DEPTH   = 16,
  parameter  bit RX_ROLE = 1'b1,
  localparam int RIW     = $clog2(NREG),
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              irq_pol,
  input  logic              irq_src,
  output logic              irq_o,
  output logic [NREG*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tws_busmon i_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tws_st_e     st_q, st_n;
  tws_ph_e     ph_q, ph_n;
  logic [3:0]  bc_q, bc_n;
  logic [7:0]  sh_q, sh_n;
  logic [15:0] ptr_q, ptr_n;
  logic        rw_q, rw_n, oe_q, oe_n, mack_q, mack_n, irq_n;
  logic        stg_clr, stg_push, base_ld, commit;
  logic [7:0]  rd_byte, id_byte;
  logic [CW-1:0] stg_cnt;

  assign id_byte = {1'b1, 2'b00, addr_sel, irq_pol, RX_ROLE, 1'b0};

  tws_regbank #(.NREG(NREG), .DEPTH(DEPTH)) i_bank (
    .clk(clk), .rst_n(rst_n), .stg_clr(stg_clr), .stg_push(stg_push),
    .stg_din(sh_q), .base_ld(base_ld), .base_in(sh_q[RIW-1:0]),
    .commit(commit), .rd_idx(ptr_q[RIW-1:0]), .id_byte(id_byte),
    .rd_byte(rd_byte), .stg_cnt(stg_cnt), .regs_o(regs_o)
  );

  always_comb begin
    st_n = st_q;  ph_n = ph_q;  bc_n = bc_q;  sh_n = sh_q;
    ptr_n = ptr_q; rw_n = rw_q; oe_n = oe_q;  mack_n = mack_q;
    stg_clr = 1'b0; stg_push = 1'b0; base_ld = 1'b0; commit = 1'b0;
    irq_n = irq_pol ~^ irq_src;
    if (start_det) begin
      st_n = S_RX; ph_n = P_DEV; bc_n = '0; oe_n = 1'b0; stg_clr = 1'b1;
    end else if (stop_det) begin
      st_n = S_IDLE; oe_n = 1'b0; commit = (stg_cnt != '0);
    end else begin
      case (st_q)
        S_RX: begin
          if (scl_rise) begin
            sh_n = {sh_q[6:0], sda_s};
            bc_n = bc_q + 4'd1;
          end else if (scl_fall && bc_q == 4'd8) begin
            st_n = S_RXACK; oe_n = 1'b1;
            case (ph_q)
              P_DEV: begin
                rw_n = sh_q[0];
                if (sh_q[7:1] != tws_dev_addr(addr_sel)) begin
                  st_n = S_IDLE; oe_n = 1'b0;
                end
              end
              P_AHI: ptr_n[15:8] = sh_q;
              P_ALO: begin ptr_n[7:0] = sh_q; base_ld = 1'b1; end
              default: begin
                if (stg_cnt < CW'(DEPTH)) begin
                  stg_push = 1'b1; ptr_n = ptr_q + 16'd1;
                end else begin
                  stg_clr = 1'b1; st_n = S_IDLE; oe_n = 1'b0;
                end
              end
            endcase
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            oe_n = 1'b0; bc_n = '0;
            if (ph_q == P_DEV && rw_q) begin
              st_n = S_TX; sh_n = rd_byte; oe_n = ~rd_byte[7];
            end else begin
              st_n = S_RX;
              case (ph_q)
                P_DEV:   ph_n = P_AHI;
                P_AHI:   ph_n = P_ALO;
                default: ph_n = P_DATA;
              endcase
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bc_q == 4'd7) begin
              oe_n = 1'b0; st_n = S_TXACK; ptr_n = ptr_q + 16'd1; mack_n = 1'b0;
            end else begin
              bc_n = bc_q + 4'd1; sh_n = {sh_q[6:0], 1'b0}; oe_n = ~sh_q[6];
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            if (sda_s) st_n = S_IDLE;
            else       mack_n = 1'b1;
          end else if (scl_fall && mack_q) begin
            st_n = S_TX; bc_n = '0; sh_n = rd_byte; oe_n = ~rd_byte[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; ph_q <= P_DEV; bc_q <= '0; sh_q <= '0; ptr_q <= '0;
      rw_q <= 1'b0; oe_q <= 1'b0; mack_q <= 1'b0; irq_o <= 1'b0;
    end else begin
      st_q <= st_n; ph_q <= ph_n; bc_q <= bc_n; sh_q <= sh_n; ptr_q <= ptr_n;
      rw_q <= rw_n; oe_q <= oe_n; mack_q <= mack_n; irq_o <= irq_n;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk #(
  parameter int NREG  = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic                  irq_pol,
  input logic                  irq_src,
  input logic                  irq_o,
  input logic [(NREG-1)*8-1:0] live_o,
  input logic [CW-1:0]         stg_cnt
);
  p_commit_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_det |=> $stable(live_o));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stg_cnt <= CW'(DEPTH));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pol && irq_src) |=> irq_o);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pol && irq_src) |=> !irq_o);

  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_release_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind tws_slave tws_slave_chk #(.NREG(NREG), .DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .irq_pol(irq_pol), .irq_src(irq_src), .irq_o(irq_o),
  .live_o(regs_o[NREG*8-1:8]), .stg_cnt(stg_cnt)
);

// File: tb/test_tws_slave.sv
`timescale 1ns/1ps
module test_tws_slave;
  localparam int H = 16;

  typedef struct packed { logic [15:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VEC [6] = '{
    '{16'h0003, 8'h5A}, '{16'h010F, 8'hC3}, '{16'h0007, 8'h01},
    '{16'hAB30, 8'hFF}, '{16'h0005, 8'h00}, '{16'h0003, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe, irq_o;
  logic [1:0] addr_sel = 2'b00;
  logic irq_pol = 1'b1, irq_src = 1'b0;
  logic [127:0] regs_o;
  wire  sda_bus = ~(m_sda_low | sda_oe);
  logic [6:0] m_dev = 7'h62;
  logic [7:0] exp_r [16];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tws_slave i_tws_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .irq_pol(irq_pol), .irq_src(irq_src), .irq_o(irq_o),
    .regs_o(regs_o)
  );

  function automatic logic [6:0] dev_of(input logic [1:0] s);
    case (s) 2'b00: return 7'h62; 2'b01: return 7'h72; 2'b10: return 7'h60; default: return 7'h70; endcase
  endfunction
  function automatic logic [7:0] id_now();
    return {1'b1, 2'b00, addr_sel, irq_pol, 1'b1, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    hw(4); m_sda_low = 1'b0; hw(H); m_scl = 1'b1; hw(H);
    m_sda_low = 1'b1; hw(H); m_scl = 1'b0;
  endtask
  task automatic m_stop();
    hw(4); m_sda_low = 1'b1; hw(H); m_scl = 1'b1; hw(H);
    m_sda_low = 1'b0; hw(H);
  endtask
  task automatic m_send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hw(4); m_sda_low = ~b[i]; hw(H-4); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    end
    hw(4); m_sda_low = 1'b0; hw(H-4); m_scl = 1'b1; hw(H/2);
    ack = ~sda_bus; hw(H/2); m_scl = 1'b0;
  endtask
  task automatic m_recv(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      hw(H); m_scl = 1'b1; hw(H/2); b[i] = sda_bus; hw(H/2); m_scl = 1'b0;
    end
    hw(4); m_sda_low = mack; hw(H-4); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    hw(4); m_sda_low = 1'b0;
  endtask
  task automatic wr_head(input logic [15:0] a, output logic ok);
    logic k1, k2, k3;
    m_start(); m_send({m_dev, 1'b0}, k1); m_send(a[15:8], k2); m_send(a[7:0], k3);
    ok = k1 & k2 & k3;
  endtask
  task automatic rd_head(input logic [15:0] a, output logic ok);
    logic k1, k2;
    wr_head(a, k1); m_start(); m_send({m_dev, 1'b1}, k2);
    ok = k1 & k2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok, ak;
    logic [7:0] b;
    int idx;
    for (int i = 0; i < 16; i++) exp_r[i] = 8'h00;
    hw(5);
    chk("R9 sda_oe in reset", sda_oe, 0);
    chk("R9 irq_o in reset", irq_o, 0);
    chk("R9 live regs zero", (regs_o[127:8] == '0), 1);
    rst_n = 1'b1; hw(5);

    // vector table: single write, commit check, combined read-back
    for (int v = 0; v < 6; v++) begin
      wr_head(VEC[v].a, ok); m_send(VEC[v].d, ak); m_stop();
      idx = int'(VEC[v].a[3:0]);
      if (idx != 0) exp_r[idx] = VEC[v].d;
      chk("R2 write acked", ok & ak, 1);
      chk(idx == 0 ? "R7 index0 ignores write" : "R3 committed at stop",
          regs_o[idx*8 +: 8], idx == 0 ? id_now() : exp_r[idx]);
      rd_head(VEC[v].a, ok); m_recv(b, 1'b0); m_stop();
      chk("R6 read back", {ok, b}, {1'b1, idx == 0 ? id_now() : exp_r[idx]});
    end

    // multi-byte write with wrap; nothing visible before stop
    wr_head(16'h000E, ok);
    m_send(8'h11, ak); ok &= ak; m_send(8'h22, ak); ok &= ak;
    m_send(8'h33, ak); ok &= ak; m_send(8'h44, ak); ok &= ak;
    chk("R2 burst acked", ok, 1);
    chk("R3 unchanged before stop r14", regs_o[14*8 +: 8], exp_r[14]);
    chk("R3 unchanged before stop r1", regs_o[1*8 +: 8], exp_r[1]);
    m_stop();
    exp_r[14] = 8'h11; exp_r[15] = 8'h22; exp_r[1] = 8'h44;
    chk("R2 burst r14", regs_o[14*8 +: 8], 8'h11);
    chk("R2 burst r15", regs_o[15*8 +: 8], 8'h22);
    chk("R2 burst wrap r1", regs_o[1*8 +: 8], 8'h44);
    chk("R7 burst skips index0", regs_o[7:0], id_now());

    // multi-byte combined read across the wrap
    rd_head(16'h000E, ok);
    chk("R6 read header acked", ok, 1);
    m_recv(b, 1'b1); chk("R6 read byte0", b, 8'h11);
    m_recv(b, 1'b1); chk("R6 read byte1", b, 8'h22);
    m_recv(b, 1'b0); chk("R6 read byte2 id", b, id_now());
    m_stop();
    chk("R10 sda released after stop", sda_oe, 0);

    // repeated start discards staged data
    wr_head(16'h0004, ok); m_send(8'h77, ak);
    m_start(); m_stop();
    chk("R4 repeated start discards", regs_o[4*8 +: 8], exp_r[4]);

    // overflow: 17th byte NACKed, nothing committed
    wr_head(16'h0001, ok);
    for (int i = 0; i < 16; i++) begin m_send(8'hA0 + 8'(i), ak); ok &= ak; end
    chk("R5 sixteen bytes acked", ok, 1);
    m_send(8'hEE, ak);
    chk("R5 17th byte nacked", ak, 0);
    m_stop();
    chk("R5 r1 unchanged", regs_o[1*8 +: 8], exp_r[1]);
    chk("R5 r2 unchanged", regs_o[2*8 +: 8], exp_r[2]);

    // address strap
    for (int s = 0; s < 4; s++) begin
      addr_sel = 2'(s); m_dev = dev_of(2'(s));
      m_start(); m_send({m_dev, 1'b0}, ak); m_stop();
      chk("R1 strap address acked", ak, 1);
    end
    addr_sel = 2'b01;
    m_start(); m_send({7'h62, 1'b0}, ak); m_stop();
    chk("R1 foreign address ignored", ak, 0);
    addr_sel = 2'b10; m_dev = dev_of(2'b10); irq_pol = 1'b0;
    rd_head(16'h0000, ok); m_recv(b, 1'b0); m_stop();
    chk("R7 identity byte", b, 8'h92);
    irq_pol = 1'b1;

    // interrupt polarity
    irq_src = 1'b0; hw(3); chk("R8 pol1 idle", irq_o, 0);
    irq_src = 1'b1; hw(3); chk("R8 pol1 event rises", irq_o, 1);
    irq_pol = 1'b0; irq_src = 1'b0; hw(3); chk("R8 pol0 idle", irq_o, 1);
    irq_src = 1'b1; hw(3); chk("R8 pol0 event falls", irq_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule